// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block gathers eight edge-triggered interrupt lines and presents them to a processor through one request output. A rising edge on an unmasked line is latched in a pending-request register. Line 0 has the highest fixed priority and line 7 the lowest. The output is raised only when a pending request outranks every level that is already being serviced. A higher-priority request can therefore interrupt the handler of a lower one, and several in-service levels can be open at the same time.

The processor answers with a one-cycle acknowledge pulse. The block moves the winning request into the in-service register and, one cycle later, returns an 8-bit vector. The vector is a software-programmed base whose three low bits are replaced by the line number. Software uses a small register port to:
- write the mask,
- set the vector base,
- read the pending and in-service registers,
- issue a non-specific end-of-interrupt, which closes the highest-priority open level.

Requests held back by an open level stay latched. They win the output again as soon as an end-of-interrupt uncovers them.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous reset the pending and in-service registers read 0x00, the mask reads 0xFF, the vector base reads 0x00, `int_out` is low and `vec_valid` is low.
- R2: When a line goes from low to high and its mask bit is 0, that line's pending bit sets after the next clock edge. A line that stays high, or that falls, sets no bit.
- R3: The mask register is at address 0, where it can be written and read back; bit n belongs to line n. An edge on a line whose mask bit is 1 is not recorded.
- R4: `int_out` is high whenever a pending request outranks every in-service level. Once high, it stays high until `int_ack` is pulsed. There is no timeout.
- R5: An `int_ack` pulse while `int_out` is high has three effects at the next edge:
  - the highest-priority pending bit clears;
  - the in-service bit for that line sets;
  - `vec_valid` goes high for one cycle with `vec_out` = {base[7:3], line}.
- R6: A pending request on a lower-numbered line than every open in-service level raises `int_out`. When acknowledged, it adds a second in-service bit.
- R7: A pending request whose line number is equal to or higher than the highest-priority open level stays pending and leaves `int_out` low.
- R8: A write to address 2 (data ignored) is a non-specific end-of-interrupt. It clears only the lowest-numbered set in-service bit. Address 2 reads the pending register.
- R9: After an end-of-interrupt, if a held request now outranks the remaining open levels, `int_out` rises in the following cycle.
- R10: An `int_ack` pulse while `int_out` is low returns `vec_out` = {base[7:3], 3'd7} with `vec_valid` high. It leaves the in-service and pending registers unchanged.
- R11: The vector base is at address 1. Only bits 7:3 are stored, and a read returns them with bits 2:0 as zero.
- R12: In-service bits clear only through end-of-interrupt. Writes to address 3, which reads the in-service register, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_valid | output | 1 | Vector valid, one cycle after an acknowledge |
| vec_out | output | 8 | Returned interrupt vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |

## Verification
Priority resolution is tried in four ways:
- A single request on an idle controller shows the plain request and acknowledge path.
- A low-priority handler interrupted by a higher line separates true nesting from a design that serialises handlers.
- Requests of equal and lower priority arriving during service show whether the comparison against open levels is strict, and whether held requests survive.
- A chain of end-of-interrupts across several open levels shows that only the top level closes, and that held requests re-raise the output in the right order.

Masked edges, held-high lines and acknowledges with nothing eligible tell edge latching apart from level sampling, and tell genuine grants apart from spurious ones.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int VEC_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK    = 2'd0,
        SEL_BASE    = 2'd1,
        SEL_REQ_EOI = 2'd2,
        SEL_SERVICE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } prio_t;

    // Lowest-numbered set bit wins (line 0 is top priority).
    function automatic prio_t pick_highest(input logic [LINES-1:0] v);
        prio_t r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [LINES-1:0] idx_to_onehot(input prio_t p);
        logic [LINES-1:0] oh;
        oh = '0;
        if (p.valid) oh[p.idx] = 1'b1;
        return oh;
    endfunction

endpackage

// File: rtl/nic_edge_latch.sv
module nic_edge_latch
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] pend
);

    logic [LINES-1:0] lines_q;
    logic [LINES-1:0] rise;

    assign rise = lines & ~lines_q & ~mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '1;
            pend    <= '0;
        end else begin
            lines_q <= lines;
            pend    <= (pend & ~clr) | rise;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_chk
        p_masked_no_record_r3: assert property (@(posedge clk) disable iff (rst)
            (mask[g] && !pend[g]) |=> !pend[g]);
        p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
            (lines[g] && !lines_q[g] && !mask[g]) |=> pend[g]);
    end

endmodule

// File: rtl/nic_resolver.sv
module nic_resolver
    import nic_pkg::*;
(
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] isr,
    output prio_t            winner,
    output logic             req
);

    prio_t top_isr;

    always_comb begin
        winner  = pick_highest(pend);
        top_isr = pick_highest(isr);
        req     = winner.valid && (!top_isr.valid || (winner.idx < top_isr.idx));
    end

    always_comb begin
        if (req) a_req_has_pending_r4: assert (pend != '0);
    end

endmodule

// File: rtl/nic_service_reg.sv
module nic_service_reg
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] set,
    input  logic             eoi,
    output logic [LINES-1:0] isr
);

    logic [LINES-1:0] eoi_clr;

    always_comb begin
        eoi_clr = eoi ? idx_to_onehot(pick_highest(isr)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= (isr & ~eoi_clr) | set;
    end

    p_eoi_single_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi && set == '0 && isr != '0) |=> ($countones(isr) + 1 == $countones($past(isr))));
    p_isr_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!eoi && set == '0) |=> $stable(isr));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter logic [VEC_W-1:0] RESET_BASE = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LINES-1:0]        irq_in,
    output logic                    int_out,
    input  logic                    int_ack,
    output logic                    vec_valid,
    output logic [VEC_W-1:0]        vec_out,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [VEC_W-1:0]        reg_wdata,
    output logic [VEC_W-1:0]        reg_rdata
);

    localparam int BASE_LSB = IDX_W;
    localparam logic [VEC_W-1:0] BASE_KEEP = {{(VEC_W-IDX_W){1'b1}}, {IDX_W{1'b0}}};

    logic [LINES-1:0] mask_q;
    logic [VEC_W-1:0] base_q;
    logic [LINES-1:0] pend;
    logic [LINES-1:0] isr;
    logic [LINES-1:0] grant_oh;
    prio_t            winner;
    logic             req;
    logic             grant;
    logic             eoi;
    reg_sel_e         sel;

    assign sel      = reg_sel_e'(reg_addr);
    assign grant    = int_ack && req;
    assign grant_oh = grant ? idx_to_onehot(winner) : '0;
    assign eoi      = reg_wr && (sel == SEL_REQ_EOI);
    assign int_out  = req;

    nic_edge_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .lines (irq_in),
        .mask  (mask_q),
        .clr   (grant_oh),
        .pend  (pend)
    );

    nic_resolver u_res (
        .pend   (pend),
        .isr    (isr),
        .winner (winner),
        .req    (req)
    );

    nic_service_reg u_svc (
        .clk (clk),
        .rst (rst),
        .set (grant_oh),
        .eoi (eoi),
        .isr (isr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            base_q <= RESET_BASE & BASE_KEEP;
        end else if (reg_wr) begin
            if (sel == SEL_MASK) mask_q <= reg_wdata[LINES-1:0];
            if (sel == SEL_BASE) base_q <= reg_wdata & BASE_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= int_ack;
            if (int_ack) begin
                vec_out <= {base_q[VEC_W-1:BASE_LSB], grant ? winner.idx : IDX_W'(LINES - 1)};
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_MASK:    reg_rdata = VEC_W'(mask_q);
            SEL_BASE:    reg_rdata = base_q;
            SEL_REQ_EOI: reg_rdata = VEC_W'(pend);
            SEL_SERVICE: reg_rdata = VEC_W'(isr);
            default:     reg_rdata = '0;
        endcase
    end

    p_int_until_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (int_out && !int_ack) |=> int_out);
    p_ack_gives_vec_r5: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> vec_valid);
    p_no_vec_unasked_r5: assert property (@(posedge clk) disable iff (rst)
        !int_ack |=> !vec_valid);
    p_grant_sets_isr_r5: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_out) |=> (isr != '0));
    p_spurious_line7_r10: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_out) |=> (vec_out[IDX_W-1:0] == IDX_W'(LINES - 1)));

endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       int_out;
    logic       int_ack;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .int_out   (int_out),
        .int_ack   (int_ack),
        .vec_valid (vec_valid),
        .vec_out   (vec_out),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic eoi();
        wr(2'd2, 8'h00);
    endtask

    task automatic pulse(input int line);
        irq_in[line] = 1'b1;
        cyc();
        irq_in[line] = 1'b0;
        cyc();
    endtask

    task automatic ack(output logic vv, output logic [7:0] v);
        int_ack = 1'b1;
        cyc();
        int_ack = 1'b0;
        vv = vec_valid;
        v = vec_out;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        rd(2'd0, d); chk("R1 mask", d, 8'hFF);
        rd(2'd1, d); chk("R1 base", d, 8'h00);
        rd(2'd2, d); chk("R1 pending", d, 8'h00);
        rd(2'd3, d); chk("R1 in-service", d, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        pulse(2);
        rd(2'd2, d); chk("R3 masked edge", d, 8'h00);
        wr(2'd0, 8'h5A);
        rd(2'd0, d); chk("R3 mask readback", d, 8'h5A);
        wr(2'd0, 8'h00);
        rd(2'd2, d); chk("R3 no late record", d, 8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] d;
        logic vv;
        logic [7:0] v;
        irq_in[3] = 1'b1;
        cyc();
        rd(2'd2, d); chk("R2 edge sets", d, 8'h08);
        chk("R4 int raised", {7'd0, int_out}, 8'h01);
        ack(vv, v);
        chk("R5 vec_valid", {7'd0, vv}, 8'h01);
        chk("R5 vector", v, 8'h03);
        rd(2'd3, d); chk("R5 isr set", d, 8'h08);
        cyc(); cyc();
        rd(2'd2, d); chk("R2 held high no reset", d, 8'h00);
        chk("R5 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
        irq_in[3] = 1'b0;
        cyc();
        rd(2'd2, d); chk("R2 falling no set", d, 8'h00);
        eoi();
        rd(2'd3, d); chk("R8 isr cleared", d, 8'h00);
    endtask

    task automatic t_hold_until_ack();
        logic [7:0] d;
        logic vv;
        logic [7:0] v;
        pulse(5);
        repeat (6) cyc();
        chk("R4 int held without ack", {7'd0, int_out}, 8'h01);
        ack(vv, v);
        chk("R5 vector line5", v, 8'h05);
        chk("R4 int drops after ack", {7'd0, int_out}, 8'h00);
        rd(2'd2, d); chk("R5 pending cleared", d, 8'h00);
        eoi();
    endtask

    task automatic t_nest_and_eoi();
        logic [7:0] d;
        logic vv;
        logic [7:0] v;
        pulse(4);
        ack(vv, v);
        pulse(1);
        chk("R6 higher raises int", {7'd0, int_out}, 8'h01);
        ack(vv, v);
        chk("R6 nested vector", v, 8'h01);
        rd(2'd3, d); chk("R6 two levels open", d, 8'h12);
        pulse(6);
        chk("R7 lower held, int low", {7'd0, int_out}, 8'h00);
        pulse(1);
        chk("R7 equal held, int low", {7'd0, int_out}, 8'h00);
        rd(2'd2, d); chk("R7 both pending", d, 8'h42);
        eoi();
        rd(2'd3, d); chk("R8 only top level cleared", d, 8'h10);
        chk("R9 held line1 re-raises", {7'd0, int_out}, 8'h01);
        ack(vv, v);
        chk("R9 vector line1", v, 8'h01);
        eoi();
        chk("R7 line6 below line4 held", {7'd0, int_out}, 8'h00);
        eoi();
        rd(2'd3, d); chk("R8 all closed", d, 8'h00);
        chk("R9 line6 re-raises", {7'd0, int_out}, 8'h01);
        ack(vv, v);
        chk("R9 vector line6", v, 8'h06);
        eoi();
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        logic vv;
        logic [7:0] v;
        ack(vv, v);
        chk("R10 spurious valid", {7'd0, vv}, 8'h01);
        chk("R10 spurious vector", v, 8'h07);
        rd(2'd3, d); chk("R10 isr untouched", d, 8'h00);
    endtask

    task automatic t_base();
        logic [7:0] d;
        logic vv;
        logic [7:0] v;
        wr(2'd1, 8'hA5);
        rd(2'd1, d); chk("R11 base low bits dropped", d, 8'hA0);
        pulse(2);
        ack(vv, v);
        chk("R11 vector with base", v, 8'hA2);
        eoi();
    endtask

    task automatic t_isr_write();
        logic [7:0] d;
        logic vv;
        logic [7:0] v;
        pulse(0);
        ack(vv, v);
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk("R12 write to isr ignored", d, 8'h01);
        repeat (3) cyc();
        rd(2'd3, d); chk("R12 no self clear", d, 8'h01);
        eoi();
        rd(2'd3, d); chk("R12 eoi clears", d, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        irq_in = '0;
        int_ack = 1'b0;
        reg_wr = 1'b0;
        reg_addr = '0;
        reg_wdata = '0;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_mask();
        t_edge();
        t_hold_until_ack();
        t_nest_and_eoi();
        t_spurious();
        t_base();
        t_isr_write();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule